// File: doc/BRIEF.md
# Dual-Channel Phase Comparator with Lock Detect

This block compares the reference strobe of each of two synthesizer channels against that channel's divided feedback strobe. Both strobes are one oscillator clock wide and are sampled on the oscillator clock. The block reports the phase error as the number of oscillator clocks from whichever strobe comes first to the other one. While the error is being measured, each channel drives a three-state pump command (push up, pull down, or high impedance). The meaning of up and down can be swapped per channel to suit the sign of the oscillator tuning slope.

Each channel also keeps a lock flag with hysteresis. Lock is lost at once when an error reaches a drop threshold. Lock is regained only after a run of consecutive small errors. A channel that is powered down stops comparing, leaves its pump at high impedance and counts as locked. The two lock flags are combined into a single status pin. For bench and board debug, that pin can instead carry either strobe of either channel.

Top module: `dual_pfd_lock`

## Requirements
- R1: With the polarity bit high, the pump command is up (cp_hi=1, cp_lo=0) while the reference strobe leads, and down (cp_hi=0, cp_lo=1) while the divided strobe leads.
- R2: With the polarity bit low, the two commands of R1 are swapped.
- R3: When both strobes arrive in the same clock, or no measurement is open, both cp_hi and cp_lo are 0 (high impedance). The two are never 1 together.
- R4: If the lagging strobe arrives k clocks after the leading one (k ≥ 1), the pump command is active for exactly k clock cycles.
- R5: A channel's lock flag clears at the clock edge on which an open measurement reaches DROP_TH clocks (default 4). This happens even before the lagging strobe has arrived.
- R6: A comparison whose error is below DROP_TH and at most GOOD_TH (default 8) counts as good. Lock is set on the GOOD_RUN-th consecutive good comparison (default 3).
- R7: A comparison that is not good resets the run of good comparisons, so lock again needs GOOD_RUN fresh good comparisons. After reset, lock is clear and the run is zero.
- R8: While a channel's power-save input is 1, its pump command is high impedance and strobes are ignored. The channel reports locked on the status pin, and its stored lock state is held.
- R9: With mon_en=0, shared_out is the AND of the two channels' reported lock flags.
- R10: With mon_en=1, shared_out carries a strobe chosen by mon_sel. mon_sel[0] picks the channel (0 is the first channel). mon_sel[1] picks the signal (0 is reference, 1 is divided).
- R11: After reset, with no channel powered down, shared_out is 0 and all pump commands are high impedance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock; the unit of phase error |
| rst_n | input | 1 | Active-low asynchronous reset |
| ref_stb | input | 2 | Reference strobe per channel, one clock wide |
| div_stb | input | 2 | Divided feedback strobe per channel, one clock wide |
| pol_pos | input | 2 | Pump polarity per channel (1: reference lead pushes up) |
| pwr_save | input | 2 | Power-save request per channel |
| mon_en | input | 1 | 1 routes a strobe to shared_out, 0 routes combined lock |
| mon_sel | input | 2 | Strobe select: bit 0 channel, bit 1 reference/divided |
| cp_hi | output | 2 | Pump push-up command per channel |
| cp_lo | output | 2 | Pump pull-down command per channel |
| shared_out | output | 1 | Combined lock flag or monitored strobe |

## Verification
The hardest case to reach from the ports is a loss of lock in the middle of a measurement, before the lagging strobe exists. To reach it, the bench first locks a channel with three small-error comparisons. It then sends a lone reference strobe and watches the status pin clock by clock, expecting the drop exactly at the fourth edge after the strobe. Only after that does it close the measurement. Isolating one channel's lock flag on the shared pin also takes care: the other channel is kept in power save, so it reports locked and the AND passes the tested channel through.

// File: rtl/pfd_pkg.sv
`timescale 1ns/1ps
package pfd_pkg;

   typedef enum logic [1:0] {
      TRK_IDLE      = 2'd0,
      TRK_REF_AHEAD = 2'd1,
      TRK_DIV_AHEAD = 2'd2
   } trk_state_e;

   function automatic int imax(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/pfd_phase_track.sv
`timescale 1ns/1ps
module pfd_phase_track #(
   parameter int ERR_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ref_stb,
   input  logic             div_stb,
   input  logic             pol_pos,
   input  logic             pwr_save,
   output logic             cp_hi,
   output logic             cp_lo,
   output logic             busy,
   output logic [ERR_W-1:0] live_err,
   output logic             meas_done,
   output logic [ERR_W-1:0] meas_err
);
   import pfd_pkg::*;

   localparam logic [ERR_W-1:0] CNT_MAX = '1;
   localparam logic [ERR_W-1:0] CNT_ONE = ERR_W'(1);

   trk_state_e       state_q, state_d;
   logic [ERR_W-1:0] cnt_q, cnt_d;

   always_comb begin
      state_d   = state_q;
      cnt_d     = cnt_q;
      meas_done = 1'b0;
      meas_err  = cnt_q;
      unique case (state_q)
         TRK_IDLE: begin
            if (ref_stb && div_stb) begin
               meas_done = 1'b1;
               meas_err  = '0;
            end else if (ref_stb) begin
               state_d = TRK_REF_AHEAD;
               cnt_d   = CNT_ONE;
            end else if (div_stb) begin
               state_d = TRK_DIV_AHEAD;
               cnt_d   = CNT_ONE;
            end
         end
         TRK_REF_AHEAD: begin
            if (div_stb) begin
               meas_done = 1'b1;
               state_d   = ref_stb ? TRK_REF_AHEAD : TRK_IDLE;
               cnt_d     = ref_stb ? CNT_ONE : '0;
            end else if (cnt_q != CNT_MAX) begin
               cnt_d = cnt_q + CNT_ONE;
            end
         end
         TRK_DIV_AHEAD: begin
            if (ref_stb) begin
               meas_done = 1'b1;
               state_d   = div_stb ? TRK_DIV_AHEAD : TRK_IDLE;
               cnt_d     = div_stb ? CNT_ONE : '0;
            end else if (cnt_q != CNT_MAX) begin
               cnt_d = cnt_q + CNT_ONE;
            end
         end
         default: begin
            state_d = TRK_IDLE;
            cnt_d   = '0;
         end
      endcase
      if (pwr_save) begin
         state_d   = TRK_IDLE;
         cnt_d     = '0;
         meas_done = 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= TRK_IDLE;
         cnt_q   <= '0;
      end else begin
         state_q <= state_d;
         cnt_q   <= cnt_d;
      end
   end

   assign busy     = (state_q != TRK_IDLE);
   assign live_err = cnt_q;
   assign cp_hi    = !pwr_save && (((state_q == TRK_REF_AHEAD) &&  pol_pos) ||
                                   ((state_q == TRK_DIV_AHEAD) && !pol_pos));
   assign cp_lo    = !pwr_save && (((state_q == TRK_REF_AHEAD) && !pol_pos) ||
                                   ((state_q == TRK_DIV_AHEAD) &&  pol_pos));

endmodule

// File: rtl/pfd_lock_judge.sv
`timescale 1ns/1ps
module pfd_lock_judge #(
   parameter int ERR_W    = 4,
   parameter int DROP_TH  = 4,
   parameter int GOOD_TH  = 8,
   parameter int GOOD_RUN = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pwr_save,
   input  logic             busy,
   input  logic [ERR_W-1:0] live_err,
   input  logic             meas_done,
   input  logic [ERR_W-1:0] meas_err,
   output logic             lock_q
);
   localparam int               RUN_W  = $clog2(GOOD_RUN + 1);
   localparam logic [ERR_W-1:0] DROP_V = ERR_W'(DROP_TH);
   localparam logic [ERR_W-1:0] GOOD_V = ERR_W'(GOOD_TH);
   localparam logic [RUN_W-1:0] RUN_V  = RUN_W'(GOOD_RUN);
   localparam logic [RUN_W-1:0] RUN_1  = RUN_W'(1);

   logic [RUN_W-1:0] run_q;
   logic [RUN_W-1:0] run_inc;
   logic             far_open, meas_good;

   assign far_open  = busy && (live_err >= DROP_V);
   assign meas_good = (meas_err < DROP_V) && (meas_err <= GOOD_V);
   assign run_inc   = (run_q >= RUN_V) ? RUN_V : run_q + RUN_1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lock_q <= 1'b0;
         run_q  <= '0;
      end else if (pwr_save) begin
         lock_q <= lock_q;
         run_q  <= run_q;
      end else if (far_open) begin
         lock_q <= 1'b0;
         run_q  <= '0;
      end else if (meas_done) begin
         if (meas_err >= DROP_V) begin
            lock_q <= 1'b0;
            run_q  <= '0;
         end else if (meas_good) begin
            run_q <= run_inc;
            if (run_inc >= RUN_V) lock_q <= 1'b1;
         end else begin
            run_q <= '0;
         end
      end
   end

endmodule

// File: rtl/pfd_pin_mux.sv
`timescale 1ns/1ps
module pfd_pin_mux (
   input  logic [1:0] ref_stb,
   input  logic [1:0] div_stb,
   input  logic [1:0] ch_lock,
   input  logic       mon_en,
   input  logic [1:0] mon_sel,
   output logic       pin_out
);
   logic mon_bit;

   always_comb begin
      unique case (mon_sel)
         2'b00:   mon_bit = ref_stb[0];
         2'b01:   mon_bit = ref_stb[1];
         2'b10:   mon_bit = div_stb[0];
         default: mon_bit = div_stb[1];
      endcase
   end

   assign pin_out = mon_en ? mon_bit : (&ch_lock);

endmodule

// File: rtl/dual_pfd_lock.sv
`timescale 1ns/1ps
module dual_pfd_lock #(
   parameter int DROP_TH  = 4,
   parameter int GOOD_TH  = 8,
   parameter int GOOD_RUN = 3
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] ref_stb,
   input  logic [1:0] div_stb,
   input  logic [1:0] pol_pos,
   input  logic [1:0] pwr_save,
   input  logic       mon_en,
   input  logic [1:0] mon_sel,
   output logic [1:0] cp_hi,
   output logic [1:0] cp_lo,
   output logic       shared_out
);
   localparam int NCH     = 2;
   localparam int ERR_CAP = pfd_pkg::imax(DROP_TH, GOOD_TH) + 1;
   localparam int ERR_W   = $clog2(ERR_CAP + 1);

   if (DROP_TH < 1) begin : g_bad_drop
      $error("DROP_TH must be at least 1");
   end
   if (GOOD_RUN < 1) begin : g_bad_run
      $error("GOOD_RUN must be at least 1");
   end

   logic [NCH-1:0]            trk_busy;
   logic [NCH-1:0][ERR_W-1:0] trk_live;
   logic [NCH-1:0]            meas_done;
   logic [NCH-1:0][ERR_W-1:0] meas_err;
   logic [NCH-1:0]            lock_q;
   logic [NCH-1:0]            ch_lock;

   for (genvar g = 0; g < NCH; g++) begin : g_ch
      pfd_phase_track #(.ERR_W(ERR_W)) u_trk (
         .clk       (clk),
         .rst_n     (rst_n),
         .ref_stb   (ref_stb[g]),
         .div_stb   (div_stb[g]),
         .pol_pos   (pol_pos[g]),
         .pwr_save  (pwr_save[g]),
         .cp_hi     (cp_hi[g]),
         .cp_lo     (cp_lo[g]),
         .busy      (trk_busy[g]),
         .live_err  (trk_live[g]),
         .meas_done (meas_done[g]),
         .meas_err  (meas_err[g])
      );

      pfd_lock_judge #(
         .ERR_W(ERR_W), .DROP_TH(DROP_TH), .GOOD_TH(GOOD_TH), .GOOD_RUN(GOOD_RUN)
      ) u_judge (
         .clk       (clk),
         .rst_n     (rst_n),
         .pwr_save  (pwr_save[g]),
         .busy      (trk_busy[g]),
         .live_err  (trk_live[g]),
         .meas_done (meas_done[g]),
         .meas_err  (meas_err[g]),
         .lock_q    (lock_q[g])
      );

      assign ch_lock[g] = lock_q[g] | pwr_save[g];
   end

   pfd_pin_mux u_mux (
      .ref_stb (ref_stb),
      .div_stb (div_stb),
      .ch_lock (ch_lock),
      .mon_en  (mon_en),
      .mon_sel (mon_sel),
      .pin_out (shared_out)
   );

endmodule

// File: rtl/dual_pfd_lock_chk.sv
`timescale 1ns/1ps
module dual_pfd_lock_chk #(
   parameter int ERR_W   = 4,
   parameter int DROP_TH = 4
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic [1:0]            pwr_save,
   input logic                  mon_en,
   input logic [1:0]            cp_hi,
   input logic [1:0]            cp_lo,
   input logic                  shared_out,
   input logic [1:0]            lock_q,
   input logic [1:0]            trk_busy,
   input logic [1:0][ERR_W-1:0] trk_live
);
   for (genvar i = 0; i < 2; i++) begin : g_a
      AST_CP_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
         !(cp_hi[i] && cp_lo[i])); // R3
      AST_SAVE_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
         pwr_save[i] |-> (!cp_hi[i] && !cp_lo[i])); // R8
      AST_FAR_DROP: assert property (@(posedge clk) disable iff (!rst_n)
         (trk_busy[i] && !pwr_save[i] && (trk_live[i] >= ERR_W'(DROP_TH))) |=> !lock_q[i]); // R5
   end

   AST_SAVE_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      (!mon_en && (pwr_save == 2'b11)) |-> shared_out); // R8

   AST_AND_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (!mon_en && ((!lock_q[0] && !pwr_save[0]) || (!lock_q[1] && !pwr_save[1]))) |-> !shared_out); // R9

endmodule

bind dual_pfd_lock dual_pfd_lock_chk #(.ERR_W(ERR_W), .DROP_TH(DROP_TH)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .pwr_save   (pwr_save),
   .mon_en     (mon_en),
   .cp_hi      (cp_hi),
   .cp_lo      (cp_lo),
   .shared_out (shared_out),
   .lock_q     (lock_q),
   .trk_busy   (trk_busy),
   .trk_live   (trk_live)
);

// File: tb/sim_dual_pfd_lock.sv
`timescale 1ns/1ps
module sim_dual_pfd_lock;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] ref_stb = '0, div_stb = '0, pol_pos = 2'b11, pwr_save = '0, mon_sel = '0;
   logic       mon_en = 1'b0;
   logic [1:0] cp_hi, cp_lo;
   logic       shared_out;

   int  n_checks = 0, n_errors = 0;
   int  good_run [2] = '{0, 0};
   bit  lk [2] = '{0, 0};
   bit  finished = 0;

   always #4 clk = ~clk;

   dual_pfd_lock u0 (
      .clk(clk), .rst_n(rst_n), .ref_stb(ref_stb), .div_stb(div_stb), .pol_pos(pol_pos),
      .pwr_save(pwr_save), .mon_en(mon_en), .mon_sel(mon_sel),
      .cp_hi(cp_hi), .cp_lo(cp_lo), .shared_out(shared_out)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic strobe(input int ch, input bit r, input bit p);
      ref_stb[ch] = r;
      div_stb[ch] = p;
      @(negedge clk);
      ref_stb = '0;
      div_stb = '0;
   endtask

   // model of the lock rule: R6 good run, R5/R7 bad result
   task automatic model_result(input int ch, input int err);
      if (err >= 4) begin
         lk[ch] = 0; good_run[ch] = 0;
      end else begin
         if (good_run[ch] < 3) good_run[ch]++;
         if (good_run[ch] >= 3) lk[ch] = 1;
      end
   endtask

   // other channel must report locked so shared_out shows this one
   task automatic chk_lock(input int ch, input string req);
      chk(shared_out == lk[ch], req, shared_out, lk[ch]);
   endtask

   // one comparison, error k; ref_first picks which strobe leads
   task automatic run_pair(input int ch, input bit ref_first, input int k);
      int  active = 0;
      bit  up_exp;
      if (k == 0) begin
         strobe(ch, 1, 1);
         chk(!cp_hi[ch] && !cp_lo[ch], "R3 same-edge high-Z", {cp_hi[ch], cp_lo[ch]}, 0);
      end else begin
         up_exp = (ref_first == pol_pos[ch]);
         strobe(ch, ref_first, !ref_first);
         for (int j = 0; j < k; j++) begin
            if (cp_hi[ch] || cp_lo[ch]) active++;
            chk(cp_hi[ch] == up_exp && cp_lo[ch] == !up_exp,
                pol_pos[ch] ? "R1 polarity" : "R2 swapped polarity",
                {cp_hi[ch], cp_lo[ch]}, {up_exp, !up_exp});
            if (j == k - 1) strobe(ch, !ref_first, ref_first);
            else tick();
         end
         chk(active == k, "R4 pump width", active, k);
         chk(!cp_hi[ch] && !cp_lo[ch], "R3 idle high-Z", {cp_hi[ch], cp_lo[ch]}, 0);
      end
      model_result(ch, k);
      chk_lock(ch, "R6 lock after comparison");
   endtask

   task automatic t_reset();
      chk(shared_out == 1'b0, "R11 lock low after reset", shared_out, 0);
      chk(cp_hi == 2'b00 && cp_lo == 2'b00, "R11 pumps high-Z", {cp_hi, cp_lo}, 0);
   endtask

   task automatic t_polarity_and_lock();
      pwr_save = 2'b10;
      pol_pos[0] = 1'b1;
      run_pair(0, 1, 2);            // R1 up
      run_pair(0, 0, 3);            // R1 down
      pol_pos[0] = 1'b0;
      run_pair(0, 1, 1);            // R2 swapped; third good result locks (R6)
      run_pair(0, 0, 2);
      run_pair(0, 1, 0);            // R3
      pol_pos[0] = 1'b1;
   endtask

   task automatic t_far_drop();
      chk(shared_out == 1'b1, "R5 locked before far lead", shared_out, 1);
      strobe(0, 1, 0);
      for (int j = 1; j <= 4; j++) begin
         tick();
         chk(shared_out == (j < 4), "R5 drop at fourth edge", shared_out, (j < 4));
      end
      strobe(0, 0, 1);
      model_result(0, 6);
      chk_lock(0, "R5 still unlocked after close");
   endtask

   task automatic t_streak();
      run_pair(0, 1, 1);
      run_pair(0, 0, 1);
      run_pair(0, 1, 5);            // R7 breaks the run
      run_pair(0, 1, 1);
      run_pair(0, 0, 2);
      chk(shared_out == 1'b0, "R7 two goods after bad not enough", shared_out, 0);
      run_pair(0, 1, 3);
      chk(shared_out == 1'b1, "R7 third fresh good locks", shared_out, 1);
   endtask

   task automatic t_save();
      pwr_save = 2'b11;
      strobe(0, 1, 0);
      chk(cp_hi[0] == 0 && cp_lo[0] == 0, "R8 pump high-Z in save", {cp_hi[0], cp_lo[0]}, 0);
      for (int j = 0; j < 6; j++) tick();
      chk(shared_out == 1'b1, "R8 saved channels report locked", shared_out, 1);
      pwr_save = 2'b10;
      tick();
      chk(shared_out == 1'b1, "R8 lock state held across save", shared_out, 1);
      chk(cp_hi[0] == 0 && cp_lo[0] == 0, "R8 strobe ignored in save", {cp_hi[0], cp_lo[0]}, 0);
      run_pair(0, 1, 2);
   endtask

   task automatic t_and();
      pwr_save = 2'b00;
      tick();
      chk(shared_out == 1'b0, "R9 one channel unlocked", shared_out, 0);
      pol_pos[1] = 1'b1;
      run_pair(1, 0, 1);
      run_pair(1, 1, 2);
      run_pair(1, 0, 0);
      chk(shared_out == 1'b1, "R9 both locked", shared_out, 1);
   endtask

   task automatic mon_case(input logic [1:0] sel);
      int ch = sel[0];
      mon_sel = sel;
      if (sel[1]) div_stb[ch] = 1'b1; else ref_stb[ch] = 1'b1;
      #1;
      chk(shared_out == 1'b1, "R10 selected strobe routed", shared_out, 1);
      ref_stb = '0; div_stb = '0;
      if (sel[1]) ref_stb[ch] = 1'b1; else div_stb[ch] = 1'b1;
      ref_stb[1-ch] = 1'b1; div_stb[1-ch] = 1'b1;
      #1;
      chk(shared_out == 1'b0, "R10 other strobes blocked", shared_out, 0);
      ref_stb = '0; div_stb = '0;
      tick();
   endtask

   task automatic t_monitor();
      pwr_save = 2'b11;
      mon_en = 1'b1;
      tick();
      for (int s = 0; s < 4; s++) mon_case(2'(s));
      mon_en = 1'b0;
      #1;
      chk(shared_out == 1'b1, "R9 lock view restored", shared_out, 1);
   endtask

   initial begin
      repeat (3) tick();
      rst_n = 1'b1;
      tick();
      t_reset();
      t_polarity_and_lock();
      t_far_drop();
      t_streak();
      t_save();
      t_and();
      t_monitor();
      finished = 1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         n_checks++;
         n_errors++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
         $finish;
      end
   end

endmodule